// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Resolver

This block joins two eight-line resolver units into one sixteen-line interrupt source. System lines 0 to 7 feed the first-level (master) unit, and lines 8 to 15 feed the second-level (slave) unit at position `index mod 8`. The slave unit never reaches the processor directly. While it holds a request that beats its own in-service state, it marks master position 2 as pending. A request on system line 2 therefore arrives only through the slave, and the external pin of that number is discarded.

The processor sees a single `int_req` output. When it answers with an acknowledge strobe, the block looks at which unit wins and registers an 8-bit vector. The vector's upper five bits come from that unit's base input and its lower three bits from the winning position. The block then marks the winner in service in each unit involved. A poll strobe is the alternative path: it reports the winning system line in a status byte and retires that line completely, with no vector formed. Separate end-of-service strobes, one per unit, release the most urgent in-service entry.

A byte-wide view of the master unit shows its pending register after reset. It switches to the in-service register at the first acknowledge.

Top module: `pic_cascade`

## Requirements
- R1: After reset `int_req` is 0, and `vector`, `poll_word` and `master_view` are 8'h00.
- R2: A request latches on a 0-to-1 change of its line. A line held high latches once and does not latch again after that request is serviced.
- R3: Within a unit, position 0 is the most urgent. A unit requests only when its most urgent pending position is strictly more urgent than its most urgent in-service position, so a pending lower-urgency line waits behind an in-service one.
- R4: A qualifying slave request sets master position 2 pending one clock later. The external pin `irq_lines[2]` has no effect.
- R5: An acknowledge with a master winner other than 2 loads `vector` with `{master_base[7:3], line}`. It moves that master position from pending to in service, and `int_req` falls in the next cycle if nothing more urgent is pending.
- R6: An acknowledge whose master winner is 2 loads `vector` with `{slave_base[7:3], slave_line}`. It moves the slave winner and master position 2 from pending to in service.
- R7: An acknowledge while `int_req` is 0 loads `vector` with `{master_base[7:3], 3'b111}` and changes no pending or in-service bit.
- R8: A poll strobe loads `poll_word` with `{1'b1, 3'b000, system_line[3:0]}` and clears both the pending and the in-service bit of the winner. For a slave winner it also clears master position 2. With no request it loads 8'h00.
- R9: `master_view` shows the master pending register until the first acknowledge, and the master in-service register from then on. A poll does not change the selection.
- R10: An end-of-service strobe clears the lowest-numbered in-service bit of its unit. Requests blocked by that bit raise `int_req` again: master positions in the next cycle, slave lines one cycle later.
- R11: `vector` and `poll_word` are registered. They change only in the cycle after their strobe and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | System request lines; bit 2 is discarded |
| ack_strobe | input | 1 | Processor acknowledge, one cycle |
| poll_strobe | input | 1 | Poll read, one cycle |
| eoi_master | input | 1 | End of service for the master unit |
| eoi_slave | input | 1 | End of service for the slave unit |
| master_base | input | 8 | Master vector base; bits 2:0 unused |
| slave_base | input | 8 | Slave vector base; bits 2:0 unused |
| int_req | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector from the last acknowledge |
| poll_word | output | 8 | Result of the last poll |
| master_view | output | 8 | Master pending or in-service register |

## Verification
The assertions assume that acknowledge and poll never arrive in the same cycle. They also assume that an end-of-service strobe never coincides with either of them, although the two end-of-service strobes may pulse together. The bench keeps to this by issuing each strobe as a one-cycle pulse from its own task, driven on the falling edge. It drops or holds request lines only at moments when no strobe is active, so every check follows from one stimulus at a time.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int UNIT_LINES = 8;
  localparam int POS_W      = $clog2(UNIT_LINES);
  localparam int RANK_W     = POS_W + 1;
  localparam int CASCADE_POS = 2;

  // Rank of the most urgent set bit; UNIT_LINES when none is set.
  function automatic logic [RANK_W-1:0] first_set(input logic [UNIT_LINES-1:0] v);
    logic [RANK_W-1:0] r;
    r = RANK_W'(UNIT_LINES);
    for (int i = UNIT_LINES - 1; i >= 0; i--)
      if (v[i]) r = RANK_W'(i);
    return r;
  endfunction

  // Vector: upper bits from the base, lower bits from the position.
  function automatic logic [7:0] compose_vec(input logic [7:0] base,
                                             input logic [POS_W-1:0] pos);
    return (base & 8'hF8) | {5'b0, pos};
  endfunction

  // Poll status: valid flag on top, system line number at the bottom.
  function automatic logic [7:0] poll_code(input logic hit, input logic [3:0] line);
    return hit ? {1'b1, 3'b000, line} : 8'h00;
  endfunction
endpackage

// File: rtl/pic_unit.sv
module pic_unit
  import pic_cascade_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [UNIT_LINES-1:0] level,
  input  logic [UNIT_LINES-1:0] force_set,
  input  logic                  ack_en,
  input  logic [POS_W-1:0]      ack_pos,
  input  logic                  clr_en,
  input  logic [POS_W-1:0]      clr_pos,
  input  logic                  eoi,
  output logic [UNIT_LINES-1:0] irr,
  output logic [UNIT_LINES-1:0] isr,
  output logic                  req,
  output logic [POS_W-1:0]      win
);
  logic [UNIT_LINES-1:0] last_q, irr_q, isr_q, irr_d, isr_d, rise;
  logic [RANK_W-1:0]     rank_pend, rank_serv;
  logic                  eoi_live;

  assign rise      = level & ~last_q;
  assign rank_pend = first_set(irr_q);
  assign rank_serv = first_set(isr_q);
  assign req       = rank_pend < rank_serv;
  assign win       = rank_pend[POS_W-1:0];
  assign eoi_live  = eoi && !rank_serv[POS_W];

  for (genvar i = 0; i < UNIT_LINES; i++) begin : g_bit
    logic ack_hit, clr_hit, eoi_hit;
    assign ack_hit  = ack_en && (ack_pos == POS_W'(i));
    assign clr_hit  = clr_en && (clr_pos == POS_W'(i));
    assign eoi_hit  = eoi_live && (rank_serv[POS_W-1:0] == POS_W'(i));
    assign irr_d[i] = (irr_q[i] && !ack_hit && !clr_hit) || rise[i] || force_set[i];
    assign isr_d[i] = (isr_q[i] || ack_hit) && !clr_hit && !eoi_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      last_q <= level;
      irr_q  <= irr_d;
      isr_q  <= isr_d;
    end
  end

  assign irr = irr_q;
  assign isr = isr_q;
endmodule

// File: rtl/pic_cascade_route.sv
module pic_cascade_route
  import pic_cascade_pkg::*;
(
  input  logic             ack_strobe,
  input  logic             poll_strobe,
  input  logic [7:0]       master_base,
  input  logic [7:0]       slave_base,
  input  logic             m_req,
  input  logic [POS_W-1:0] m_win,
  input  logic             s_req,
  input  logic [POS_W-1:0] s_win,
  output logic             m_ack_en,
  output logic             s_ack_en,
  output logic             m_clr_en,
  output logic             s_clr_en,
  output logic [7:0]       vec_next,
  output logic [7:0]       poll_next
);
  logic via_slave;
  assign via_slave = m_req && (m_win == POS_W'(CASCADE_POS));

  assign m_ack_en = ack_strobe && m_req;
  assign s_ack_en = ack_strobe && via_slave && s_req;
  assign m_clr_en = poll_strobe && m_req;
  assign s_clr_en = poll_strobe && via_slave && s_req;

  always_comb begin
    if (!m_req)
      vec_next = compose_vec(master_base, POS_W'(UNIT_LINES - 1));
    else if (via_slave)
      vec_next = compose_vec(slave_base, s_req ? s_win : POS_W'(UNIT_LINES - 1));
    else
      vec_next = compose_vec(master_base, m_win);
  end

  always_comb begin
    if (!m_req)
      poll_next = poll_code(1'b0, 4'd0);
    else if (via_slave)
      poll_next = poll_code(s_req, {1'b1, s_win});
    else
      poll_next = poll_code(1'b1, {1'b0, m_win});
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_cascade_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_lines,
  input  logic        ack_strobe,
  input  logic        poll_strobe,
  input  logic        eoi_master,
  input  logic        eoi_slave,
  input  logic [7:0]  master_base,
  input  logic [7:0]  slave_base,
  output logic        int_req,
  output logic [7:0]  vector,
  output logic [7:0]  poll_word,
  output logic [7:0]  master_view
);
  logic [UNIT_LINES-1:0] m_irr, m_isr, s_irr, s_isr, m_level, m_force;
  logic                  m_req, s_req, cas_feed;
  logic [POS_W-1:0]      m_win, s_win;
  logic                  m_ack_en, s_ack_en, m_clr_en, s_clr_en;
  logic [7:0]            vec_next, poll_next, vector_q, poll_q;
  logic                  view_isr_q;

  // Master position 2 is the cascade input, never the external pin.
  always_comb begin
    m_level = irq_lines[UNIT_LINES-1:0];
    m_level[CASCADE_POS] = 1'b0;
    m_force = '0;
    m_force[CASCADE_POS] = cas_feed;
  end
  assign cas_feed = s_req && !ack_strobe && !poll_strobe;

  pic_cascade_route u_route (
    .ack_strobe (ack_strobe), .poll_strobe(poll_strobe),
    .master_base(master_base), .slave_base(slave_base),
    .m_req(m_req), .m_win(m_win), .s_req(s_req), .s_win(s_win),
    .m_ack_en(m_ack_en), .s_ack_en(s_ack_en),
    .m_clr_en(m_clr_en), .s_clr_en(s_clr_en),
    .vec_next(vec_next), .poll_next(poll_next)
  );

  pic_unit u_master (
    .clk(clk), .rst_n(rst_n), .level(m_level), .force_set(m_force),
    .ack_en(m_ack_en), .ack_pos(m_win), .clr_en(m_clr_en), .clr_pos(m_win),
    .eoi(eoi_master), .irr(m_irr), .isr(m_isr), .req(m_req), .win(m_win)
  );

  pic_unit u_slave (
    .clk(clk), .rst_n(rst_n), .level(irq_lines[15:UNIT_LINES]), .force_set('0),
    .ack_en(s_ack_en), .ack_pos(s_win), .clr_en(s_clr_en), .clr_pos(s_win),
    .eoi(eoi_slave), .irr(s_irr), .isr(s_isr), .req(s_req), .win(s_win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vector_q   <= 8'h00;
      poll_q     <= 8'h00;
      view_isr_q <= 1'b0;
    end else begin
      if (ack_strobe) begin
        vector_q   <= vec_next;
        view_isr_q <= 1'b1;
      end
      if (poll_strobe) poll_q <= poll_next;
    end
  end

  assign int_req     = m_req;
  assign vector      = vector_q;
  assign poll_word   = poll_q;
  assign master_view = view_isr_q ? m_isr : m_irr;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_strobe,
  input logic       poll_strobe,
  input logic       eoi_master,
  input logic       int_req,
  input logic [7:0] vector,
  input logic [7:0] poll_word,
  input logic [7:0] master_view,
  input logic [7:0] m_irr,
  input logic [7:0] m_isr,
  input logic [7:0] s_irr,
  input logic [7:0] s_isr,
  input logic       s_req
);
  // Input discipline: one command per cycle (R8)
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_strobe, poll_strobe}));

  p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe && !int_req |=> vector[2:0] == 3'd7);

  p_ack_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe && int_req |=> m_isr != 8'h00);

  p_view_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |=> master_view == m_isr);

  p_cascade_feed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !ack_strobe && !poll_strobe |=> m_irr[2]);

  p_poll_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_strobe && !int_req |=> poll_word == 8'h00);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_strobe && !poll_strobe |=> $stable(vector) && $stable(poll_word));

  p_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_master && !ack_strobe && !poll_strobe && (m_isr != 8'h00)
    |=> $countones(m_isr) == $countones($past(m_isr)) - 1);

  p_slave_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_strobe && int_req && m_irr[2] && (m_irr[1:0] == 2'b00) && s_req
    |=> !m_irr[2] && !m_isr[2] && ($countones(s_irr | s_isr) < $countones($past(s_irr | s_isr))));
endmodule

bind pic_cascade pic_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_strobe(ack_strobe), .poll_strobe(poll_strobe),
  .eoi_master(eoi_master), .int_req(int_req), .vector(vector),
  .poll_word(poll_word), .master_view(master_view),
  .m_irr(m_irr), .m_isr(m_isr), .s_irr(s_irr), .s_isr(s_isr), .s_req(s_req)
);

// File: tb/pic_cascade_tb.sv
module pic_cascade_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic        ack_strobe, poll_strobe, eoi_master, eoi_slave;
  logic [7:0]  master_base, slave_base;
  logic        int_req;
  logic [7:0]  vector, poll_word, master_view;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  always #5 clk = ~clk;

  pic_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .ack_strobe(ack_strobe), .poll_strobe(poll_strobe),
    .eoi_master(eoi_master), .eoi_slave(eoi_slave),
    .master_base(master_base), .slave_base(slave_base),
    .int_req(int_req), .vector(vector), .poll_word(poll_word),
    .master_view(master_view)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack_strobe = 1'b1; @(negedge clk); ack_strobe = 1'b0;
  endtask

  task automatic do_poll();
    poll_strobe = 1'b1; @(negedge clk); poll_strobe = 1'b0;
  endtask

  task automatic do_eoi(input logic m, input logic s);
    eoi_master = m; eoi_slave = s; @(negedge clk);
    eoi_master = 1'b0; eoi_slave = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 int_req", {7'b0, int_req}, 8'h00);
    check("R1 vector", vector, 8'h00);
    check("R1 poll_word", poll_word, 8'h00);
    check("R1 master_view", master_view, 8'h00);
  endtask

  task automatic t_master_ack();
    irq_lines[5] = 1'b1; wait_cyc(1);
    check("R2 edge latched", {7'b0, int_req}, 8'h01);
    check("R9 view shows pending", master_view, 8'h20);
    irq_lines[5] = 1'b0;
    do_ack();
    check("R5 master vector", vector, 8'h25);
    check("R5 int_req falls", {7'b0, int_req}, 8'h00);
    check("R9 view shows in-service", master_view, 8'h20);
    do_eoi(1'b1, 1'b0);
    check("R10 eoi clears", master_view, 8'h00);
  endtask

  task automatic t_slave_ack();
    irq_lines[11] = 1'b1; wait_cyc(1);
    check("R4 slave needs extra cycle", {7'b0, int_req}, 8'h00);
    wait_cyc(1);
    check("R4 cascade raises int_req", {7'b0, int_req}, 8'h01);
    irq_lines[11] = 1'b0;
    do_ack();
    check("R6 slave vector", vector, 8'h73);
    check("R6 master pos2 in service", master_view, 8'h04);
    do_eoi(1'b1, 1'b1);
    check("R10 both released", master_view, 8'h00);
  endtask

  task automatic t_priority();
    irq_lines[6] = 1'b1; irq_lines[1] = 1'b1; wait_cyc(1);
    irq_lines[6] = 1'b0; irq_lines[1] = 1'b0;
    do_ack();
    check("R3 lower index wins", vector, 8'h21);
    check("R3 nested blocks line 6", {7'b0, int_req}, 8'h00);
    do_eoi(1'b1, 1'b0);
    check("R10 re-raised after eoi", {7'b0, int_req}, 8'h01);
    do_ack();
    check("R3 second winner", vector, 8'h26);
    do_eoi(1'b1, 1'b0);
  endtask

  task automatic t_spurious();
    do_ack();
    check("R7 spurious vector", vector, 8'h27);
    check("R7 no in-service change", master_view, 8'h00);
  endtask

  task automatic t_base_low_bits();
    master_base = 8'h23;
    irq_lines[4] = 1'b1; wait_cyc(1); irq_lines[4] = 1'b0;
    do_ack();
    check("R5 base low bits unused", vector, 8'h24);
    do_eoi(1'b1, 1'b0);
    master_base = 8'h20;
  endtask

  task automatic t_held_level();
    irq_lines[0] = 1'b1; wait_cyc(1);
    do_ack();
    check("R5 line 0 vector", vector, 8'h20);
    do_eoi(1'b1, 1'b0);
    wait_cyc(2);
    check("R2 held level not re-latched", {7'b0, int_req}, 8'h00);
    irq_lines[0] = 1'b0; wait_cyc(1);
  endtask

  task automatic t_poll_master();
    irq_lines[3] = 1'b1; wait_cyc(1); irq_lines[3] = 1'b0;
    do_poll();
    check("R8 poll master", poll_word, 8'h83);
    check("R8 poll retires", {7'b0, int_req}, 8'h00);
    check("R9 poll keeps in-service view", master_view, 8'h00);
    check("R11 vector held", vector, 8'h20);
  endtask

  task automatic t_poll_slave();
    irq_lines[14] = 1'b1; wait_cyc(2); irq_lines[14] = 1'b0;
    do_poll();
    check("R8 poll slave", poll_word, 8'h8E);
    wait_cyc(2);
    check("R8 slave path fully cleared", {7'b0, int_req}, 8'h00);
    do_poll();
    check("R8 poll empty", poll_word, 8'h00);
  endtask

  task automatic t_pin2_ignored();
    irq_lines[2] = 1'b1; wait_cyc(3);
    check("R4 pin 2 ignored", {7'b0, int_req}, 8'h00);
    irq_lines[2] = 1'b0; wait_cyc(1);
  endtask

  task automatic t_chained();
    irq_lines[9] = 1'b1; irq_lines[12] = 1'b1; wait_cyc(2);
    irq_lines[9] = 1'b0; irq_lines[12] = 1'b0;
    do_ack();
    check("R6 first slave line", vector, 8'h71);
    check("R3 slave nested", {7'b0, int_req}, 8'h00);
    do_eoi(1'b1, 1'b1);
    check("R10 slave re-raise pending", {7'b0, int_req}, 8'h00);
    wait_cyc(1);
    check("R10 slave re-raised", {7'b0, int_req}, 8'h01);
    do_ack();
    check("R6 second slave line", vector, 8'h74);
    do_eoi(1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; irq_lines = '0;
    ack_strobe = 1'b0; poll_strobe = 1'b0; eoi_master = 1'b0; eoi_slave = 1'b0;
    master_base = 8'h20; slave_base = 8'h70;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_master_ack();
    t_slave_ack();
    t_priority();
    t_spurious();
    t_base_low_bits();
    t_held_level();
    t_poll_master();
    t_poll_slave();
    t_pin2_ignored();
    t_chained();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule